// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Request Controller

This block keeps the four status flags of a double-buffered SPI peripheral and turns them into two CPU interrupt requests. The flags are: transmit buffer empty, receive buffer full, receive overrun and mode fault. The SPI core reports what happens on the serial side as single-cycle event pulses: the transmit buffer handed a byte to the shifter, a received byte completed, or a mode fault was detected. The register file reports CPU accesses as single-cycle strobes: a status read, a receive-data read, a transmit-data write and a control write.

Software never writes a flag directly. The transmit-empty flag is cleared by writing the transmit data register. Each of the other flags is cleared by a two-access sequence: first a status read while that flag is set, then a specific follow-up access. The block also drives a receive-buffer load enable to the data path, so that a byte arriving while the previous one is still unread does not overwrite it.

The configuration inputs are held levels:
- `cfg_spe` is the enable.
- `cfg_tx_ie`, `cfg_rx_ie` and `cfg_err_ie` are the three interrupt enables.
- `cfg_modf_en` permits mode-fault detection.

Top module: `spi_flag_irq_ctrl`

## Requirements
- R1: Out of reset, `flag_tx_empty` is 1 and `flag_rx_full`, `flag_overrun`, `flag_mode_fault`, `irq_tx` and `irq_rx_err` are 0.
- R2: A `tx_load_evt` pulse sets `flag_tx_empty` at the next clock edge. A `txd_wr` pulse clears it at the next clock edge. No other access clears it.
- R3: A `rx_done_evt` pulse while `flag_rx_full` is 0 sets `flag_rx_full` at the next edge. In that same cycle `rx_capture` is 1.
- R4: `flag_rx_full` is cleared by an `rxd_rd` that follows, in a later cycle, a `stat_rd` made while `flag_rx_full` was 1. An `rxd_rd` without such a preceding status read leaves the flag set.
- R5: A `rx_done_evt` pulse while `flag_rx_full` is 1 sets `flag_overrun` at the next edge. In that cycle `rx_capture` is 0, and `flag_rx_full` stays 1.
- R6: `flag_overrun` is cleared by an `rxd_rd` that follows, in a later cycle, a `stat_rd` made while `flag_overrun` was 1.
- R7: A `mode_fault_evt` pulse sets `flag_mode_fault` only while `cfg_modf_en` is 1. While `cfg_modf_en` is 0, the flag is 0 from the next edge on.
- R8: `flag_mode_fault` is cleared by a `ctrl_wr` that follows, in a later cycle, a `stat_rd` made while `flag_mode_fault` was 1.
- R9: `irq_tx` equals `flag_tx_empty & cfg_tx_ie & cfg_spe`.
- R10: `irq_rx_err` equals `(flag_rx_full & cfg_rx_ie) | (cfg_err_ie & (flag_overrun | flag_mode_fault))`. It does not depend on `cfg_spe`.
- R11: When a setting event and a clearing access for the same flag fall in the same cycle, the flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load_evt | input | 1 | Transmit buffer byte moved into the shifter |
| rx_done_evt | input | 1 | Received byte completed in the shifter |
| mode_fault_evt | input | 1 | Mode fault detected by the core |
| stat_rd | input | 1 | CPU read of the status/control register |
| rxd_rd | input | 1 | CPU read of the receive data register |
| txd_wr | input | 1 | CPU write of the transmit data register |
| ctrl_wr | input | 1 | CPU write of the control register |
| cfg_spe | input | 1 | Peripheral enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cfg_modf_en | input | 1 | Mode-fault detection enable |
| flag_tx_empty | output | 1 | Transmit buffer empty flag |
| flag_rx_full | output | 1 | Receive buffer full flag |
| flag_overrun | output | 1 | Receive overrun flag |
| flag_mode_fault | output | 1 | Mode fault flag |
| rx_capture | output | 1 | Load enable for the receive data buffer |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rx_err | output | 1 | Receiver/error interrupt request |

## Verification
The block has results at two different times:
- Flags are registered, so they reflect an event or access one clock edge after the cycle that carries it.
- The two requests follow the flags and the enables in the same cycle.
- `rx_capture` is combinational on the current event and the current receive-full flag.

The bench drives each stimulus on the falling edge. At that point it queues the flag and request values it expects after the next rising edge. A monitor compares them shortly after that edge. `rx_capture` is checked separately, just after the drive and before the edge, because it is due in the same cycle as its event.

// File: rtl/spi_flag_pkg.sv
// Package: shared flag bundle and the clearing style selector for the
// SPI status flag controller.
package spi_flag_pkg;

    // Clearing style of one status flag
    typedef enum logic {
        CLR_DIRECT   = 1'b0,   // single access clears
        CLR_SEQUENCE = 1'b1    // status read then follow-up access clears
    } clr_style_e;

    // Bundle of the four status flags
    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic overrun;
        logic mode_fault;
    } spi_flags_t;

endpackage

// File: rtl/spi_seq_flag.sv
// Module: spi_seq_flag
// One sticky status flag. It is set by an event and cleared by either one
// access (CLR_DIRECT) or an armed two-access sequence (CLR_SEQUENCE).
// In the sequence style, a status read taken while the flag is 1 arms the
// clear, and a later follow-up access performs it. A set event in the same
// cycle as a clear wins. force_clr_i holds the flag at 0 and overrides all.
// Assumes all inputs are single-cycle, synchronous strobes.
module spi_seq_flag
    import spi_flag_pkg::*;
#(
    parameter clr_style_e STYLE   = CLR_SEQUENCE,
    parameter logic       RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    input  logic force_clr_i,
    output logic flag_o
);

    logic flag_q;
    logic arm_q;
    logic clr_ok;

    // Pick the clearing condition for the configured style
    generate
        if (STYLE == CLR_DIRECT) begin : g_direct
            assign clr_ok = clr_acc_i;
        end else begin : g_seq
            assign clr_ok = clr_acc_i & arm_q;
        end
    endgenerate

    // Arm the clear on a status read that sees the flag set; consume on clear
    always_ff @(posedge clk) begin
        if (!rst_n)              arm_q <= 1'b0;
        else if (clr_ok)         arm_q <= 1'b0;
        else if (!flag_q)        arm_q <= 1'b0;
        else if (stat_rd_i)      arm_q <= 1'b1;
    end

    // Flag register: forced clear, then set priority, then clear
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= RST_VAL;
        else if (force_clr_i)    flag_q <= 1'b0;
        else if (set_i)          flag_q <= 1'b1;
        else if (clr_ok)         flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !force_clr_i) |=> flag_o);

    // R4
    no_clear_without_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_acc_i && !force_clr_i) |=> flag_o);

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (flag_o == RST_VAL));

endmodule

// File: rtl/spi_irq_gen.sv
// Module: spi_irq_gen
// Combines the flags with the enables into the two CPU requests. The
// transmit request needs the peripheral enable. The receive/error request
// does not. Both error flags share the error enable.
// Assumes the flags come from registers, so both requests are glitch-free.
module spi_irq_gen
    import spi_flag_pkg::*;
(
    input  spi_flags_t flags_i,
    input  logic       spe_i,
    input  logic       tx_ie_i,
    input  logic       rx_ie_i,
    input  logic       err_ie_i,
    output logic       irq_tx_o,
    output logic       irq_rx_err_o
);

    logic err_any;

    // Request combination for both vectors
    always_comb begin
        err_any      = flags_i.overrun | flags_i.mode_fault;
        irq_tx_o     = flags_i.tx_empty & tx_ie_i & spe_i;
        irq_rx_err_o = (flags_i.rx_full & rx_ie_i) | (err_any & err_ie_i);
    end

    // R9
    tx_gate_chk: assert final (!(irq_tx_o && !spe_i));

endmodule

// File: rtl/spi_flag_irq_ctrl.sv
// Module: spi_flag_irq_ctrl (top)
// Holds the four status flags of a double-buffered SPI and drives its two
// interrupt requests. It also tells the data path whether a completed byte
// may be loaded into the receive buffer: not while the previous byte is
// still unread.
// Assumes that events and access strobes are one-cycle pulses and that the
// configuration inputs are quasi-static levels.
module spi_flag_irq_ctrl
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load_evt,
    input  logic rx_done_evt,
    input  logic mode_fault_evt,
    input  logic stat_rd,
    input  logic rxd_rd,
    input  logic txd_wr,
    input  logic ctrl_wr,
    input  logic cfg_spe,
    input  logic cfg_tx_ie,
    input  logic cfg_rx_ie,
    input  logic cfg_err_ie,
    input  logic cfg_modf_en,
    output logic flag_tx_empty,
    output logic flag_rx_full,
    output logic flag_overrun,
    output logic flag_mode_fault,
    output logic rx_capture,
    output logic irq_tx,
    output logic irq_rx_err
);

    spi_flags_t flags;
    logic       ovr_set;
    logic       modf_set;

    // Event qualification: a byte completing into a full buffer is an overrun
    always_comb begin
        rx_capture = rx_done_evt & ~flags.rx_full;
        ovr_set    = rx_done_evt &  flags.rx_full;
        modf_set   = mode_fault_evt & cfg_modf_en;
    end

    spi_seq_flag #(.STYLE(CLR_DIRECT), .RST_VAL(1'b1)) u_tx_empty (
        .clk(clk), .rst_n(rst_n), .set_i(tx_load_evt), .stat_rd_i(stat_rd),
        .clr_acc_i(txd_wr), .force_clr_i(1'b0), .flag_o(flags.tx_empty));

    spi_seq_flag #(.STYLE(CLR_SEQUENCE), .RST_VAL(1'b0)) u_rx_full (
        .clk(clk), .rst_n(rst_n), .set_i(rx_done_evt), .stat_rd_i(stat_rd),
        .clr_acc_i(rxd_rd), .force_clr_i(1'b0), .flag_o(flags.rx_full));

    spi_seq_flag #(.STYLE(CLR_SEQUENCE), .RST_VAL(1'b0)) u_overrun (
        .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .stat_rd_i(stat_rd),
        .clr_acc_i(rxd_rd), .force_clr_i(1'b0), .flag_o(flags.overrun));

    spi_seq_flag #(.STYLE(CLR_SEQUENCE), .RST_VAL(1'b0)) u_mode_fault (
        .clk(clk), .rst_n(rst_n), .set_i(modf_set), .stat_rd_i(stat_rd),
        .clr_acc_i(ctrl_wr), .force_clr_i(~cfg_modf_en), .flag_o(flags.mode_fault));

    spi_irq_gen u_irq (
        .flags_i(flags), .spe_i(cfg_spe), .tx_ie_i(cfg_tx_ie),
        .rx_ie_i(cfg_rx_ie), .err_ie_i(cfg_err_ie),
        .irq_tx_o(irq_tx), .irq_rx_err_o(irq_rx_err));

    // Flag outputs
    assign flag_tx_empty   = flags.tx_empty;
    assign flag_rx_full    = flags.rx_full;
    assign flag_overrun    = flags.overrun;
    assign flag_mode_fault = flags.mode_fault;

    // R2
    tx_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !tx_load_evt) |=> !flag_tx_empty);

    // R5
    overrun_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_evt && flag_rx_full) |=> (flag_overrun && flag_rx_full));

    // R3
    capture_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_capture |=> flag_rx_full);

    // R7
    modf_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_modf_en |=> !flag_mode_fault);

    // R10
    rx_req_no_spe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rx_full && cfg_rx_ie) |-> irq_rx_err);

    // R9
    tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_tx_empty && cfg_tx_ie && cfg_spe) |-> irq_tx);

endmodule

// File: tb/spi_flag_irq_ctrl_tb.sv
// Scoreboard bench: the driver applies one stimulus per cycle and queues the
// state the requirements predict. The monitor compares it after the edge.
module spi_flag_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    localparam int E_TXL  = 0;
    localparam int E_RXD  = 1;
    localparam int E_MF   = 2;
    localparam int E_STAT = 3;
    localparam int E_RDR  = 4;
    localparam int E_TDW  = 5;
    localparam int E_CTW  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_load_evt = 0, rx_done_evt = 0, mode_fault_evt = 0;
    logic stat_rd = 0, rxd_rd = 0, txd_wr = 0, ctrl_wr = 0;
    logic cfg_spe = 0, cfg_tx_ie = 0, cfg_rx_ie = 0, cfg_err_ie = 0, cfg_modf_en = 0;
    logic flag_tx_empty, flag_rx_full, flag_overrun, flag_mode_fault;
    logic rx_capture, irq_tx, irq_rx_err;

    // Pending configuration, copied onto the pins at the next drive
    logic c_spe = 0, c_tie = 0, c_rie = 0, c_eie = 0, c_men = 0;

    // Bench model state
    logic m_te = 1, m_rf = 0, m_ov = 0, m_mf = 0;
    logic a_rf = 0, a_ov = 0, a_mf = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    spi_flag_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tx_load_evt(tx_load_evt), .rx_done_evt(rx_done_evt),
        .mode_fault_evt(mode_fault_evt), .stat_rd(stat_rd), .rxd_rd(rxd_rd),
        .txd_wr(txd_wr), .ctrl_wr(ctrl_wr), .cfg_spe(cfg_spe), .cfg_tx_ie(cfg_tx_ie),
        .cfg_rx_ie(cfg_rx_ie), .cfg_err_ie(cfg_err_ie), .cfg_modf_en(cfg_modf_en),
        .flag_tx_empty(flag_tx_empty), .flag_rx_full(flag_rx_full),
        .flag_overrun(flag_overrun), .flag_mode_fault(flag_mode_fault),
        .rx_capture(rx_capture), .irq_tx(irq_tx), .irq_rx_err(irq_rx_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] pack_exp();
        return {m_te, m_rf, m_ov, m_mf, m_te & c_tie & c_spe,
                (m_rf & c_rie) | (c_eie & (m_ov | m_mf))};
    endfunction

    // Driver: apply one cycle of stimulus and queue the predicted state
    task automatic step(input logic [6:0] ev, input string tag);
        logic cap, n_te, n_rf, n_ov, n_mf, clr_rf, clr_ov, clr_mf;
        @(negedge clk);
        cfg_spe = c_spe; cfg_tx_ie = c_tie; cfg_rx_ie = c_rie;
        cfg_err_ie = c_eie; cfg_modf_en = c_men;
        tx_load_evt = ev[E_TXL]; rx_done_evt = ev[E_RXD]; mode_fault_evt = ev[E_MF];
        stat_rd = ev[E_STAT]; rxd_rd = ev[E_RDR]; txd_wr = ev[E_TDW]; ctrl_wr = ev[E_CTW];
        cap    = ev[E_RXD] & ~m_rf;
        clr_rf = ev[E_RDR] & a_rf;
        clr_ov = ev[E_RDR] & a_ov;
        clr_mf = ev[E_CTW] & a_mf;
        n_te = ev[E_TXL] ? 1'b1 : (ev[E_TDW] ? 1'b0 : m_te);
        n_rf = ev[E_RXD] ? 1'b1 : (clr_rf ? 1'b0 : m_rf);
        n_ov = (ev[E_RXD] & m_rf) ? 1'b1 : (clr_ov ? 1'b0 : m_ov);
        n_mf = !c_men ? 1'b0 : (ev[E_MF] ? 1'b1 : (clr_mf ? 1'b0 : m_mf));
        a_rf = clr_rf ? 1'b0 : (!m_rf ? 1'b0 : (ev[E_STAT] ? 1'b1 : a_rf));
        a_ov = clr_ov ? 1'b0 : (!m_ov ? 1'b0 : (ev[E_STAT] ? 1'b1 : a_ov));
        a_mf = clr_mf ? 1'b0 : (!m_mf ? 1'b0 : (ev[E_STAT] ? 1'b1 : a_mf));
        m_te = n_te; m_rf = n_rf; m_ov = n_ov; m_mf = n_mf;
        exp_q.push_back(pack_exp());
        tag_q.push_back(tag);
        #1;
        if (ev[E_RXD]) begin
            checks++;
            if (rx_capture !== cap) begin
                fails++;
                $display("FAIL %s rx_capture actual=%b expected=%b", tag, rx_capture, cap);
            end
        end
    endtask

    // Monitor: compare the queued state just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            logic [5:0] got, want;
            string t;
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            got  = {flag_tx_empty, flag_rx_full, flag_overrun, flag_mode_fault, irq_tx, irq_rx_err};
            checks++;
            if (got !== want) begin
                fails++;
                $display("FAIL %s {te,rf,ov,mf,itx,irx} actual=%b expected=%b", t, got, want);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if ({flag_tx_empty, flag_rx_full, flag_overrun, flag_mode_fault, irq_tx, irq_rx_err} !== 6'b100000) begin
            fails++;
            $display("FAIL R1 reset actual=%b expected=100000",
                     {flag_tx_empty, flag_rx_full, flag_overrun, flag_mode_fault, irq_tx, irq_rx_err});
        end
        step(7'd0, "R1 idle");
        // Transmit flag and request
        c_spe = 1; c_tie = 1;
        step(7'd0, "R9 tx request enabled");
        step(7'(1 << E_TDW), "R2 write clears tx empty");
        step(7'(1 << E_STAT), "R2 status read does not clear");
        step(7'(1 << E_TXL), "R2 load sets tx empty");
        c_spe = 0;
        step(7'd0, "R9 tx request gated by enable");
        step(7'((1 << E_TXL) | (1 << E_TDW)), "R11 load beats write");
        // Receive full
        c_rie = 1;
        step(7'(1 << E_RXD), "R3 byte sets rx full");
        step(7'(1 << E_RDR), "R4 unarmed data read ignored");
        step(7'(1 << E_STAT), "R4 status read arms");
        step(7'(1 << E_RDR), "R4 data read clears");
        step(7'(1 << E_RXD), "R3 second byte");
        step(7'(1 << E_RXD), "R5 overrun");
        c_eie = 1;
        step(7'(1 << E_STAT), "R10 error request");
        step(7'(1 << E_RDR), "R6 overrun and full cleared");
        step(7'(1 << E_RXD), "R3 refill");
        step(7'(1 << E_STAT), "R11 arm");
        step(7'((1 << E_RDR) | (1 << E_RXD)), "R11 completion beats clear");
        step(7'(1 << E_STAT), "R6 arm overrun");
        step(7'(1 << E_RDR), "R6 overrun cleared");
        // Mode fault
        c_rie = 0;
        step(7'(1 << E_MF), "R7 fault ignored when disabled");
        c_men = 1;
        step(7'(1 << E_MF), "R7 fault sets flag");
        step(7'(1 << E_CTW), "R8 unarmed control write ignored");
        step(7'(1 << E_STAT), "R8 arm");
        step(7'(1 << E_CTW), "R8 control write clears");
        step(7'(1 << E_MF), "R7 fault again");
        c_men = 0;
        step(7'd0, "R7 disable forces clear");
        c_eie = 0; c_rie = 1; c_spe = 0;
        step(7'(1 << E_RXD), "R10 rx request without enable");
        step(7'd0, "R10 hold");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule